// File: doc/BRIEF.md
# Bidirectional GPIO Port with Address-Bus Override

This block is one eight-bit general-purpose I/O port on a microcontroller peripheral bus. Software reaches it through a small register interface: a two-bit register address, a write strobe, a read strobe and byte-wide data. Three registers are visible. The output latch holds the values that pins in output mode drive. The direction register picks input or output for each pin on its own. The pull-up option register holds one enable bit that covers the whole port.

On the pin side each bit has an output value, an output enable, a pull-up enable and an input. Inputs pass through a two-flop synchroniser before anything reads them. When the expansion input is high, all eight pins drive the upper byte of the external address instead. The registers still accept writes during that time, and the stored values take effect again once the expansion input goes low.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset every pin is an input: `pad_oe` is all zeros and `pad_pu` is all zeros. The direction register resets to all ones and the pull-up option resets to 0. The output latch has no defined reset value.
- R2: A write to address 0 loads the output latch. Each pin in output mode drives its latch bit on `pad_out` and asserts its `pad_oe` bit.
- R3: A write to address 1 sets the direction of every bit in one byte-wide write, with 1 = input and 0 = output. Each bit's `pad_oe` depends only on its own direction bit.
- R4: The direction register cannot be read. A read of address 1 returns 0x00, and the read leaves every register unchanged.
- R5: Bit 0 of address 2 is the pull-up option. A read of address 2 returns that bit in bit 0 and zeros in bits 7:1. Reads of address 3 return 0x00.
- R6: `pad_pu[i]` is 1 only when the pull-up option is set, pin i is an input and the override is off. A pin never has `pad_pu` and `pad_oe` set at the same time.
- R7: A read of address 0 returns, for each bit, the latch bit if that pin is an output and the synchronised pin level if it is an input. Read data appears on `rd_data` one clock after the edge that samples `rd_en`.
- R8: A change on `pad_in` becomes visible to reads only after two clock edges of synchronisation. A read sampled on the first or second edge after the change still returns the old level.
- R9: While `ext_mode` is 1, `pad_out` equals `ext_addr_hi`, `pad_oe` is all ones and `pad_pu` is all zeros.
- R10: Writes to the latch and the direction register during the override update those registers. Their values appear on the pins as soon as `ext_mode` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ext_mode | input | 1 | Address-bus override enable |
| ext_addr_hi | input | 8 | Address bits 15:8 driven in override |
| pad_in | input | 8 | Pin levels (asynchronous) |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pad_pu | output | 8 | Pin pull-up enables |

## Verification
The bench reads the direction address after loading a non-zero direction. A design that mapped the direction register onto the read bus would return that value instead of zero. It checks that the per-bit read mix picks the latch for output pins and the pin level for input pins; swapping the selection exposes a reversed direction encoding. It times reads right after a pin change, which catches a synchroniser that is one stage short or missing. It then writes the registers during the override and releases it, so a design that blocked those writes, or let the latch leak through during the override, drives the wrong pins.

// File: rtl/gpio_pkg.sv
// Package: shared address map and widths for the GPIO port.
// Assumes a two-bit register address space with one byte per register.
package gpio_pkg;
    localparam int ADDR_W = 2;
    typedef logic [ADDR_W-1:0] reg_addr_t;
    localparam reg_addr_t ADDR_DATA = 2'd0;
    localparam reg_addr_t ADDR_DIR  = 2'd1;
    localparam reg_addr_t ADDR_PULL = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-flop synchroniser for the asynchronous pin inputs.
// Assumes the inputs are quasi-static relative to clk; the flops reset to zero.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [1:0]       age;

    // Move the pin levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Count cycles since reset, saturating at two; used only by the check below.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2))); // R8
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Register file: output latch, write-only direction register and pull-up
// option, plus the registered read multiplexer.
// Assumes wr_en and rd_en are single-cycle strobes.
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  gpio_pkg::reg_addr_t    addr,
    input  logic                   wr_en,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic                   rd_en,
    input  logic [WIDTH-1:0]       pin_sync,
    output logic [WIDTH-1:0]       latch_q,
    output logic [WIDTH-1:0]       dir_q,
    output logic                   pull_q,
    output logic [WIDTH-1:0]       rd_data
);
    import gpio_pkg::*;

    logic [WIDTH-1:0] rd_next;
    logic [WIDTH-1:0] port_view;

    // Output latch: deliberately has no reset, loaded by byte writes only.
    always_ff @(posedge clk) begin
        if (wr_en && addr == ADDR_DATA) latch_q <= wr_data;
    end

    // Direction register: full-byte writes only, resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)                         dir_q <= '1;
        else if (wr_en && addr == ADDR_DIR) dir_q <= wr_data;
    end

    // Pull-up option bit, taken from bit 0 of the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pull_q <= 1'b0;
        else if (wr_en && addr == ADDR_PULL) pull_q <= wr_data[0];
    end

    // Per-bit mix: latch for output bits, synchronised pin for input bits.
    assign port_view = (latch_q & ~dir_q) | (pin_sync & dir_q);

    // Read multiplexer; the direction address reads as zero.
    always_comb begin
        unique case (addr)
            ADDR_DATA: rd_next = port_view;
            ADDR_PULL: rd_next = {{(WIDTH-1){1'b0}}, pull_q};
            default:   rd_next = '0;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    AST_DIR_RESET_ONES: assert property (@(posedge clk)
        $past(!rst_n) |-> (dir_q == '1)); // R1
    AST_DIR_NOT_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_DIR) |=> (rd_data == '0)); // R4
    AST_DIR_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> $stable(dir_q)); // R4
endmodule

// File: rtl/gpio_pinmux.sv
// Module: gpio_pinmux
// Pin-side multiplexer: selects between the latch/direction settings and
// the external address override, and gates the pull-up.
// Assumes the override drives every pin as an output.
module gpio_pinmux #(
    parameter int WIDTH = 8
) (
    input  logic             ovr_en,
    input  logic [WIDTH-1:0] ovr_val,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             pull_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    // One slice per pin: override wins, else latch and direction apply.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            pad_out[i] = ovr_en ? ovr_val[i] : latch_q[i];
            pad_oe[i]  = ovr_en | ~dir_q[i];
            pad_pu[i]  = pull_q & dir_q[i] & ~ovr_en;
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
// Module: gpio_port_ovr (top)
// Eight-bit GPIO port with register interface and address-bus override.
// Assumes a single clock domain for the bus; pad_in may be asynchronous.
module gpio_port_ovr #(
    parameter int WIDTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [gpio_pkg::ADDR_W-1:0] addr,
    input  logic                        wr_en,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic                        rd_en,
    output logic [WIDTH-1:0]            rd_data,
    input  logic                        ext_mode,
    input  logic [WIDTH-1:0]            ext_addr_hi,
    input  logic [WIDTH-1:0]            pad_in,
    output logic [WIDTH-1:0]            pad_out,
    output logic [WIDTH-1:0]            pad_oe,
    output logic [WIDTH-1:0]            pad_pu
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic             pull_q;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (pad_in), .q (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wr_data (wr_data), .rd_en (rd_en), .pin_sync (pin_sync),
        .latch_q (latch_q), .dir_q (dir_q), .pull_q (pull_q),
        .rd_data (rd_data)
    );

    gpio_pinmux #(.WIDTH(WIDTH)) u_mux (
        .ovr_en (ext_mode), .ovr_val (ext_addr_hi), .latch_q (latch_q),
        .dir_q (dir_q), .pull_q (pull_q), .pad_out (pad_out),
        .pad_oe (pad_oe), .pad_pu (pad_pu)
    );

    AST_PU_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0)); // R6
    AST_OVR_ALL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (pad_oe == '1 && pad_pu == '0 && pad_out == ext_addr_hi)); // R9
    AST_RESET_INPUTS: assert property (@(posedge clk)
        ($past(!rst_n) && !ext_mode) |-> (pad_oe == '0 && pad_pu == '0)); // R1
endmodule

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       wr_en, rd_en, ext_mode;
    logic [7:0] wr_data, ext_addr_hi, pad_in;
    logic [7:0] rd_data, pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ovr u0 (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
        .ext_mode (ext_mode), .ext_addr_hi (ext_addr_hi), .pad_in (pad_in),
        .pad_out (pad_out), .pad_oe (pad_oe), .pad_pu (pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 oe after reset", pad_oe, 8'h00);
        check("R1 pu after reset", pad_pu, 8'h00);
        bus_read(2'd2, v);
        check("R5 pull option reset", v, 8'h00);
        bus_read(2'd3, v);
        check("R5 unused address", v, 8'h00);
    endtask

    task automatic t_drive();
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'hA5);
        @(negedge clk);
        check("R3 oe per direction", pad_oe, 8'h0F);
        check("R2 latch on output pins", pad_out & 8'h0F, 8'h05);
    endtask

    task automatic t_walk_dir();
        for (int i = 0; i < 8; i++) begin
            bus_write(2'd1, ~(8'h01 << i));
            @(negedge clk);
            check("R3 single output bit", pad_oe, 8'h01 << i);
        end
        bus_write(2'd1, 8'hF0);
    endtask

    task automatic t_dir_hidden();
        logic [7:0] v;
        bus_read(2'd1, v);
        check("R4 direction reads zero", v, 8'h00);
        @(negedge clk);
        check("R4 read left direction alone", pad_oe, 8'h0F);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        pad_in = 8'h3C;
        repeat (4) @(negedge clk);
        bus_read(2'd0, v);
        check("R7 mixed read", v, 8'h35);
    endtask

    task automatic t_sync();
        @(negedge clk);
        pad_in = 8'hC3; addr = 2'd0; rd_en = 1'b1;
        @(negedge clk);
        check("R8 first edge old level", rd_data, 8'h35);
        @(negedge clk);
        check("R8 second edge old level", rd_data, 8'h35);
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 new level after two stages", rd_data, 8'hC5);
    endtask

    task automatic t_pull();
        logic [7:0] v;
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, v);
        check("R5 pull option readback", v, 8'h01);
        check("R6 pu on input pins", pad_pu, 8'hF0);
        bus_write(2'd2, 8'hFE);
        bus_read(2'd2, v);
        check("R5 only bit 0 used", v, 8'h00);
        check("R6 pu off", pad_pu, 8'h00);
        bus_write(2'd2, 8'h01);
    endtask

    task automatic t_override();
        @(negedge clk);
        ext_addr_hi = 8'h9E; ext_mode = 1'b1;
        @(negedge clk);
        check("R9 address on pins", pad_out, 8'h9E);
        check("R9 all pins drive", pad_oe, 8'hFF);
        check("R9 pull-up off", pad_pu, 8'h00);
        bus_write(2'd0, 8'h12);
        bus_write(2'd1, 8'h00);
        check("R10 latch hidden in override", pad_out, 8'h9E);
        @(negedge clk);
        ext_mode = 1'b0;
        @(negedge clk);
        check("R10 latch after release", pad_out, 8'h12);
        check("R10 direction after release", pad_oe, 8'hFF);
        check("R6 no pu on outputs", pad_pu, 8'h00);
        bus_write(2'd1, 8'h0F);
        @(negedge clk);
        check("R6 pu back on inputs", pad_pu, 8'h0F);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        ext_mode = 1'b0; ext_addr_hi = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_walk_dir();
        t_dir_hidden();
        t_readback();
        t_sync();
        t_pull();
        t_override();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule